// File: doc/BRIEF.md
# Immediate Barrel Shifter with Carry

This block is the operand shifter of a 32-bit integer datapath. It takes one source value and a two-bit shift kind, and returns the shifted value and the bit last shifted out. The amount comes from one of two places. In immediate mode it is a five-bit field of the instruction. In register mode it is a full eight-bit count taken from a register. An incoming carry flag feeds the rotate-through-carry form. It is also passed back unchanged whenever the shifter must not alter the flag.

A separate output, `carryValid`, tells the flag logic downstream whether `carryOut` is to be written. It is set only when the instruction asks for flag updates and the shift really moves bits.

In immediate mode an amount of zero does not mean "no shift" for three of the four kinds. For the two right shifts it means a shift by the full width. For rotate it means a one-bit rotate through the carry flag.

By default the block is purely combinational. When the `REG_OUT` parameter is set, a single output register stage is added for timing. That stage is cleared by an asynchronous active-low reset.

Top module: `barrel_shift_imm`

## Requirements
- R1: `shiftType` encodes 0 = logical left, 1 = logical right, 2 = arithmetic right, 3 = rotate right. `regMode` = 0 selects the 5-bit `immAmount`; `regMode` = 1 selects the 8-bit `regAmount`. An immediate logical left by n in 1..31 gives `operand << n` with carry-out `operand[32-n]`.
- R2: Immediate logical left with amount 0 returns `operand` unchanged. `carryOut` equals `carryIn` and `carryValid` is 0.
- R3: Immediate logical right with amount 0 is a shift by 32: result 0, carry-out `operand[31]`. Immediate logical right, arithmetic right or rotate by n in 1..31 give carry-out `operand[n-1]`.
- R4: Immediate arithmetic right with amount 0 is a shift by 32: every result bit equals `operand[31]`, and the carry-out is `operand[31]`.
- R5: Immediate rotate with amount 0 is rotate-through-carry: result `{carryIn, operand[31:1]}`, carry-out `operand[0]`.
- R6: With `updateFlags` = 0, `carryValid` is 0 and `carryOut` equals `carryIn` for every shift. The result is the same as with `updateFlags` = 1, except for register-mode rotate (see R10).
- R7: A register-mode amount of 0 returns `operand` unchanged, with `carryOut` = `carryIn` and `carryValid` = 0.
- R8: In register mode, a logical shift by exactly 32 gives result 0, with carry-out `operand[0]` for left and `operand[31]` for right. A logical shift by more than 32 gives result 0 and carry-out 0.
- R9: A register-mode arithmetic right shift by 32 or more fills the result with `operand[31]` and gives carry-out `operand[31]`.
- R10: A register-mode rotate with `updateFlags` = 0 rotates by `regAmount[4:0]` only. With `updateFlags` = 1 and a nonzero amount, it rotates by the amount modulo 32 and gives carry-out equal to result bit 31. For a nonzero multiple of 32, this means result = `operand` and carry-out `operand[31]`.
- R11: With `REG_OUT` = 1, all outputs appear one clock after their inputs, and they read 0 while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rstN | input | 1 | Asynchronous active-low reset |
| operand | input | 32 | Value to shift |
| shiftType | input | 2 | Shift kind (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| regMode | input | 1 | 1 selects the register amount, 0 the immediate |
| immAmount | input | 5 | Immediate shift amount |
| regAmount | input | 8 | Register-specified shift amount |
| updateFlags | input | 1 | Instruction wants the carry flag written |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Shifted value |
| carryOut | output | 1 | Shifter carry, or `carryIn` when not updated |
| carryValid | output | 1 | Carry flag should be written with `carryOut` |

## Verification
The hardest cases to reach are at the seams between the amount interpretations. These are immediate zero against register zero, a register amount of exactly 32 against 33, and a register rotate by a nonzero multiple of 32, where the result looks unshifted but the carry must still change. The stimulus reaches them with two nested sweeps. The first covers all four kinds and every register amount from 0 to 40, with both flag settings and both carry values. The second covers every immediate amount. Each point is compared with a bit-by-bit reference model. A short table of hand-worked vectors pins the named corner values. A second, registered instance is used to check the reset value and the one-cycle latency.

// File: rtl/barrel_shift_imm_pkg.sv
package barrel_shift_imm_pkg;
  localparam int DATA_W = 32;
  localparam int LOG_W  = $clog2(DATA_W);
  localparam int CNT_W  = LOG_W + 1;

  typedef enum logic [1:0] {
    KIND_LSL = 2'd0,
    KIND_LSR = 2'd1,
    KIND_ASR = 2'd2,
    KIND_ROR = 2'd3
  } shKind_t;

  typedef enum logic [2:0] {
    OP_PASS,
    OP_LSL,
    OP_LSR,
    OP_ASR,
    OP_ROR,
    OP_RRX,
    OP_ZERO
  } shOp_t;

  typedef struct packed {
    shOp_t            op;
    logic [CNT_W-1:0] amount;
    logic             carryUpd;
  } shCtrl_t;
endpackage

// File: rtl/barrel_shift_ctrl.sv
module barrel_shift_ctrl
  import barrel_shift_imm_pkg::*;
#(
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       shiftType,
  input  logic             regMode,
  input  logic [LOG_W-1:0] immAmount,
  input  logic [AMT_W-1:0] regAmount,
  input  logic             updateFlags,
  output shCtrl_t          ctrl
);
  localparam logic [AMT_W-1:0] fullAmt = AMT_W'(DATA_W);
  localparam logic [CNT_W-1:0] fullCnt = CNT_W'(DATA_W);

  shKind_t kind;
  assign kind = shKind_t'(shiftType);

  always_comb begin
    ctrl.op     = OP_PASS;
    ctrl.amount = '0;
    if (!regMode) begin
      unique case (kind)
        KIND_LSL: begin
          ctrl.op     = (immAmount == '0) ? OP_PASS : OP_LSL;
          ctrl.amount = CNT_W'(immAmount);
        end
        KIND_LSR: begin
          ctrl.op     = OP_LSR;
          ctrl.amount = (immAmount == '0) ? fullCnt : CNT_W'(immAmount);
        end
        KIND_ASR: begin
          ctrl.op     = OP_ASR;
          ctrl.amount = (immAmount == '0) ? fullCnt : CNT_W'(immAmount);
        end
        default: begin
          ctrl.op     = (immAmount == '0) ? OP_RRX : OP_ROR;
          ctrl.amount = CNT_W'(immAmount);
        end
      endcase
    end else if (kind == KIND_ROR && !updateFlags) begin
      ctrl.op     = OP_ROR;
      ctrl.amount = CNT_W'(regAmount[LOG_W-1:0]);
    end else if (regAmount == '0) begin
      ctrl.op = OP_PASS;
    end else begin
      unique case (kind)
        KIND_LSL, KIND_LSR: begin
          if (regAmount > fullAmt) begin
            ctrl.op = OP_ZERO;
          end else begin
            ctrl.op     = (kind == KIND_LSL) ? OP_LSL : OP_LSR;
            ctrl.amount = CNT_W'(regAmount);
          end
        end
        KIND_ASR: begin
          ctrl.op     = OP_ASR;
          ctrl.amount = (regAmount >= fullAmt) ? fullCnt : CNT_W'(regAmount);
        end
        default: begin
          ctrl.op     = OP_ROR;
          ctrl.amount = CNT_W'(regAmount[LOG_W-1:0]);
        end
      endcase
    end
    ctrl.carryUpd = updateFlags && (ctrl.op != OP_PASS);
  end

  // R2
  lsl_zero_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regMode && shiftType == 2'd0 && immAmount == '0) |-> ctrl.op == OP_PASS);

  // R10
  ror_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regMode && shiftType == 2'd3 && !updateFlags)
      |-> (ctrl.amount == CNT_W'(regAmount[LOG_W-1:0]) && !ctrl.carryUpd));
endmodule

// File: rtl/barrel_shift_path.sv
module barrel_shift_path
  import barrel_shift_imm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  input  shCtrl_t           ctrl,
  output logic [DATA_W-1:0] shResult,
  output logic              shCarry,
  output logic              shValid
);
  logic [2*DATA_W-1:0]        wideLeft;
  logic [2*DATA_W-1:0]        wideRight;
  logic signed [2*DATA_W-1:0] wideArith;
  logic [2*DATA_W-1:0]        wideRot;
  logic signed [2*DATA_W-1:0] arithSrc;

  assign arithSrc  = {operand, {DATA_W{1'b0}}};
  assign wideLeft  = {{DATA_W{1'b0}}, operand} << ctrl.amount;
  assign wideRight = {operand, {DATA_W{1'b0}}} >> ctrl.amount;
  assign wideArith = arithSrc >>> ctrl.amount;
  assign wideRot   = {operand, operand} >> ctrl.amount[LOG_W-1:0];

  logic [DATA_W-1:0] rawResult;
  logic              rawCarry;

  always_comb begin
    rawResult = operand;
    rawCarry  = carryIn;
    unique case (ctrl.op)
      OP_LSL: begin
        rawResult = wideLeft[DATA_W-1:0];
        rawCarry  = wideLeft[DATA_W];
      end
      OP_LSR: begin
        rawResult = wideRight[2*DATA_W-1:DATA_W];
        rawCarry  = wideRight[DATA_W-1];
      end
      OP_ASR: begin
        rawResult = wideArith[2*DATA_W-1:DATA_W];
        rawCarry  = wideArith[DATA_W-1];
      end
      OP_ROR: begin
        rawResult = wideRot[DATA_W-1:0];
        rawCarry  = wideRot[DATA_W-1];
      end
      OP_RRX: begin
        rawResult = {carryIn, operand[DATA_W-1:1]};
        rawCarry  = operand[0];
      end
      OP_ZERO: begin
        rawResult = '0;
        rawCarry  = 1'b0;
      end
      default: begin
        rawResult = operand;
        rawCarry  = carryIn;
      end
    endcase
  end

  assign shResult = rawResult;
  assign shCarry  = ctrl.carryUpd ? rawCarry : carryIn;
  assign shValid  = ctrl.carryUpd;

  // R5
  rrx_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_RRX)
      |-> (shResult[DATA_W-1] == carryIn && shResult[DATA_W-2:0] == operand[DATA_W-1:1]
           && (!shValid || shCarry == operand[0])));

  // R8
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_ZERO) |-> (shResult == '0 && (!shValid || !shCarry)));

  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_ASR && ctrl.amount == CNT_W'(DATA_W))
      |-> (shResult == {DATA_W{operand[DATA_W-1]}}));

  // R7
  pass_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_PASS) |-> (shResult == operand && shCarry == carryIn && !shValid));
endmodule

// File: rtl/barrel_shift_imm.sv
module barrel_shift_imm
  import barrel_shift_imm_pkg::*;
#(
  parameter int AMT_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  input  logic [1:0]        shiftType,
  input  logic              regMode,
  input  logic [LOG_W-1:0]  immAmount,
  input  logic [AMT_W-1:0]  regAmount,
  input  logic              updateFlags,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              carryValid
);
  shCtrl_t           ctrl;
  logic [DATA_W-1:0] shResult;
  logic              shCarry;
  logic              shValid;

  barrel_shift_ctrl #(.AMT_W(AMT_W)) ctrlUnit (
    .clk(clk), .rstN(rstN), .shiftType(shiftType), .regMode(regMode),
    .immAmount(immAmount), .regAmount(regAmount), .updateFlags(updateFlags),
    .ctrl(ctrl)
  );

  barrel_shift_path pathUnit (
    .clk(clk), .rstN(rstN), .operand(operand), .carryIn(carryIn), .ctrl(ctrl),
    .shResult(shResult), .shCarry(shCarry), .shValid(shValid)
  );

  generate
    if (REG_OUT) begin : gOutReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          result     <= '0;
          carryOut   <= 1'b0;
          carryValid <= 1'b0;
        end else begin
          result     <= shResult;
          carryOut   <= shCarry;
          carryValid <= shValid;
        end
      end
    end else begin : gOutComb
      assign result     = shResult;
      assign carryOut   = shCarry;
      assign carryValid = shValid;
    end
  endgenerate

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updateFlags |-> (!shValid && shCarry == carryIn));
endmodule

// File: tb/barrel_shift_imm_test.sv
module barrel_shift_imm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  shiftType = '0;
  logic        regMode = 1'b0;
  logic [4:0]  immAmount = '0;
  logic [7:0]  regAmount = '0;
  logic        updateFlags = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] result, resultR;
  logic        carryOut, carryOutR, carryValid, carryValidR;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_imm uut (
    .clk(clk), .rstN(rstN), .operand(operand), .shiftType(shiftType),
    .regMode(regMode), .immAmount(immAmount), .regAmount(regAmount),
    .updateFlags(updateFlags), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .carryValid(carryValid)
  );

  barrel_shift_imm #(.REG_OUT(1'b1)) uutReg (
    .clk(clk), .rstN(rstN), .operand(operand), .shiftType(shiftType),
    .regMode(regMode), .immAmount(immAmount), .regAmount(regAmount),
    .updateFlags(updateFlags), .carryIn(carryIn),
    .result(resultR), .carryOut(carryOutR), .carryValid(carryValidR)
  );

  // {op, type, regMode, regAmt, immAmt, flags, cin, expResult, expCarry, expValid}
  localparam logic [83:0] VECS [NVEC] = '{
    {32'h8000_0001, 2'd0, 1'b0, 8'd0,  5'd1, 1'b1, 1'b0, 32'h0000_0002, 1'b1, 1'b1}, // R1
    {32'h8000_0001, 2'd0, 1'b0, 8'd0,  5'd0, 1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b0}, // R2
    {32'h8000_0000, 2'd1, 1'b0, 8'd0,  5'd0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R3
    {32'h8000_0010, 2'd2, 1'b0, 8'd0,  5'd0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b1}, // R4
    {32'h0000_0003, 2'd3, 1'b0, 8'd0,  5'd0, 1'b1, 1'b1, 32'h8000_0001, 1'b1, 1'b1}, // R5
    {32'h0000_0003, 2'd3, 1'b0, 8'd0,  5'd0, 1'b1, 1'b0, 32'h0000_0001, 1'b1, 1'b1}, // R5
    {32'h1234_5678, 2'd3, 1'b0, 8'd0,  5'd4, 1'b1, 1'b0, 32'h8123_4567, 1'b1, 1'b1}, // R3
    {32'h0000_0001, 2'd0, 1'b1, 8'd32, 5'd0, 1'b1, 1'b0, 32'h0000_0000, 1'b1, 1'b1}, // R8
    {32'hFFFF_FFFF, 2'd1, 1'b1, 8'd33, 5'd0, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b1}, // R8
    {32'h0000_00F0, 2'd3, 1'b1, 8'd36, 5'd0, 1'b0, 1'b1, 32'h0000_000F, 1'b1, 1'b0}, // R10 R6
    {32'hABCD_0000, 2'd1, 1'b1, 8'd0,  5'd0, 1'b1, 1'b0, 32'hABCD_0000, 1'b0, 1'b0}, // R7
    {32'h8000_0000, 2'd3, 1'b1, 8'd64, 5'd0, 1'b1, 1'b0, 32'h8000_0000, 1'b1, 1'b1}  // R10
  };

  function automatic logic [33:0] refShift(input logic [31:0] op, input logic [1:0] ty,
      input logic rm, input logic [7:0] ra, input logic [4:0] ia,
      input logic fl, input logic ci);
    int n;
    int k;
    logic [31:0] r;
    logic c;
    logic v;
    logic doShift;
    r = op; c = ci; v = 1'b0; doShift = 1'b0; n = 0;
    if (!rm) begin
      n = int'(ia);
      if (ty == 2'd0 && n == 0) doShift = 1'b0;
      else if (ty == 2'd3 && n == 0) begin
        r = {ci, op[31:1]}; c = op[0]; v = 1'b1;
      end else begin
        if (n == 0) n = 32;
        doShift = 1'b1;
      end
    end else begin
      n = int'(ra);
      if (ty == 2'd3 && !fl) begin
        n = n % 32;
        doShift = 1'b1;
      end else if (n != 0) doShift = 1'b1;
    end
    if (doShift) begin
      v = 1'b1;
      for (int i = 0; i < 32; i++) begin
        case (ty)
          2'd0: r[i] = (i - n >= 0) ? op[i-n] : 1'b0;
          2'd1: r[i] = (i + n < 32) ? op[i+n] : 1'b0;
          2'd2: r[i] = (i + n < 32) ? op[i+n] : op[31];
          default: r[i] = op[(i + (n % 32)) % 32];
        endcase
      end
      case (ty)
        2'd0: c = (n <= 32) ? op[32-n] : 1'b0;
        2'd1: c = (n <= 32) ? op[n-1] : 1'b0;
        2'd2: c = (n <= 32) ? op[n-1] : op[31];
        default: begin
          k = n % 32;
          c = (k == 0) ? op[31] : op[k-1];
        end
      endcase
    end
    if (!fl) begin c = ci; v = 1'b0; end
    return {v, c, r};
  endfunction

  task automatic compare(input string tag, input logic [31:0] gotR, input logic gotC,
      input logic gotV, input logic [31:0] expR, input logic expC, input logic expV);
    checks++;
    if (gotR !== expR || gotC !== expC || gotV !== expV) begin
      fails++;
      $display("FAIL %s: got result=%h carry=%b valid=%b expected result=%h carry=%b valid=%b",
               tag, gotR, gotC, gotV, expR, expC, expV);
    end
  endtask

  task automatic drive(input logic [31:0] op, input logic [1:0] ty, input logic rm,
      input logic [7:0] ra, input logic [4:0] ia, input logic fl, input logic ci);
    @(negedge clk);
    operand = op; shiftType = ty; regMode = rm; regAmount = ra;
    immAmount = ia; updateFlags = fl; carryIn = ci;
    #1;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [33:0] exp;
    logic [31:0] pats [4];
    pats[0] = 32'h8000_0001; pats[1] = 32'h1234_5678;
    pats[2] = 32'hF0F0_0F0F; pats[3] = 32'h7FFF_FFFE;

    // R11 reset state of the registered variant
    drive(32'hFFFF_FFFF, 2'd2, 1'b0, 8'd0, 5'd0, 1'b1, 1'b1);
    @(posedge clk); #1;
    compare("R11 reset", resultR, carryOutR, carryValidR, 32'h0, 1'b0, 1'b0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [83:0] vv;
      vv = VECS[i];
      drive(vv[83:52], vv[51:50], vv[49], vv[48:41], vv[40:36], vv[35], vv[34]);
      compare($sformatf("R1-table vector %0d", i), result, carryOut, carryValid,
              vv[33:2], vv[1], vv[0]);
    end

    // R1 R2 R3 R4 R5 R6: immediate sweep
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a < 32; a++)
          for (int f = 0; f < 4; f++) begin
            drive(pats[p], 2'(t), 1'b0, 8'd0, 5'(a), f[1], f[0]);
            exp = refShift(pats[p], 2'(t), 1'b0, 8'd0, 5'(a), f[1], f[0]);
            compare("R3 immediate sweep", result, carryOut, carryValid,
                    exp[31:0], exp[32], exp[33]);
          end

    // R7 R8 R9 R10 R6: register sweep over 0..40
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 4; t++)
        for (int a = 0; a <= 40; a++)
          for (int f = 0; f < 4; f++) begin
            drive(pats[p], 2'(t), 1'b1, 8'(a), 5'd0, f[1], f[0]);
            exp = refShift(pats[p], 2'(t), 1'b1, 8'(a), 5'd0, f[1], f[0]);
            compare("R8 register sweep", result, carryOut, carryValid,
                    exp[31:0], exp[32], exp[33]);
          end

    // R9 large arithmetic amount
    drive(32'h8000_0000, 2'd2, 1'b1, 8'd255, 5'd0, 1'b1, 1'b0);
    compare("R9 asr 255", result, carryOut, carryValid, 32'hFFFF_FFFF, 1'b1, 1'b1);

    // R11 one-cycle latency of the registered variant
    drive(32'h1234_5678, 2'd3, 1'b0, 8'd0, 5'd4, 1'b1, 1'b0);
    @(posedge clk); #1;
    compare("R11 registered", resultR, carryOutR, carryValidR, 32'h8123_4567, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule